// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic-logic unit assembled from a row of identical one-bit cells. Each cell forms the AND, the OR and a full-adder sum of its operand bits, and passes a carry to its upper neighbour. A shared result multiplexer then picks one of these per bit, or the compare bit for the lowest position. A 3-bit control word chooses the operation. Its top bit inverts operand B in every cell and also seeds the carry into cell 0, so that one line turns the adder into a two's-complement subtractor.

The signed compare ("set if less") takes the sign of `a - b` from the top cell and corrects it with the overflow term. The corrected bit is routed back to bit 0 of the result, and every other result bit is forced low. A zero flag reports an all-zero result, so an equality test is a subtract followed by a look at that flag. A signed overflow flag, taken as the XOR of the carries entering and leaving the top cell, is reported for add and subtract only.

Top module: `alu_sliced_core`

## Requirements
- R1: Control 3'b000 gives the bitwise AND of `opnd_a` and `opnd_b` on `alu_out`.
- R2: Control 3'b001 gives the bitwise OR of `opnd_a` and `opnd_b` on `alu_out`.
- R3: Control 3'b010 gives `opnd_a + opnd_b` modulo 2^WIDTH on `alu_out`.
- R4: Control 3'b110 gives `opnd_a + ~opnd_b + 1` (that is, `opnd_a - opnd_b`) modulo 2^WIDTH on `alu_out`.
- R5: Control 3'b111 gives `alu_out` = 1 when `opnd_a` is less than `opnd_b` as signed two's-complement values and 0 otherwise. This holds even when the internal subtraction overflows, and bits WIDTH-1..1 are always 0.
- R6: `zero_flag` is 1 exactly when every bit of `alu_out` is 0, for every control value.
- R7: For add and subtract, `ovf_flag` is 1 exactly when the signed result does not fit in WIDTH bits, which is the XOR of the carry into and the carry out of bit WIDTH-1.
- R8: `ovf_flag` is 0 for AND, OR, set-if-less and the unused control values.
- R9: The unused control values 3'b011, 3'b100 and 3'b101 give `alu_out` = 0, so `zero_flag` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (32) | First operand |
| opnd_b | input | WIDTH (32) | Second operand; inverted in every cell for subtract and compare |
| alu_ctl | input | 3 | {invert-B/carry-seed, 2-bit function select} |
| alu_out | output | WIDTH (32) | Operation result |
| zero_flag | output | 1 | High when `alu_out` is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The bench targets signed compares where the difference overflows, such as the most negative value against 1 and the most positive value against -1. A compare that used only the raw sign bit would invert its answer on exactly these pairs. It also drives sums that wrap to zero, with and without signed overflow, to expose an overflow flag taken from the carry out alone or a zero flag computed before the result mask. The unused control codes are driven with non-zero operands, because a decoder that fell through to the adder or logic path would leak a value and clear the zero flag. Logic and compare operations on operands whose arithmetic would overflow catch an overflow flag that is not gated to add and subtract.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // Per-bit result choice made by the shared result multiplexer
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  localparam int CTL_W = 3;

  // Control word = {invert_b, function select}
  localparam logic [CTL_W-1:0] CTL_AND = 3'b000;
  localparam logic [CTL_W-1:0] CTL_OR  = 3'b001;
  localparam logic [CTL_W-1:0] CTL_ADD = 3'b010;
  localparam logic [CTL_W-1:0] CTL_SUB = 3'b110;
  localparam logic [CTL_W-1:0] CTL_SLT = 3'b111;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_slice_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_word,
  output logic             b_invert,
  output logic             carry_seed,
  output slice_sel_e       res_sel,
  output logic             code_valid,
  output logic             arith_op
);

  always_comb begin
    b_invert   = 1'b0;
    carry_seed = 1'b0;
    res_sel    = SEL_AND;
    code_valid = 1'b0;
    arith_op   = 1'b0;
    case (ctl_word)
      CTL_AND: begin
        res_sel    = SEL_AND;
        code_valid = 1'b1;
      end
      CTL_OR: begin
        res_sel    = SEL_OR;
        code_valid = 1'b1;
      end
      CTL_ADD: begin
        res_sel    = SEL_SUM;
        code_valid = 1'b1;
        arith_op   = 1'b1;
      end
      CTL_SUB: begin
        b_invert   = 1'b1;
        carry_seed = 1'b1;
        res_sel    = SEL_SUM;
        code_valid = 1'b1;
        arith_op   = 1'b1;
      end
      CTL_SLT: begin
        b_invert   = 1'b1;
        carry_seed = 1'b1;
        res_sel    = SEL_LESS;
        code_valid = 1'b1;
      end
      default: begin
        code_valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic a_bit,
  input  logic b_bit,
  input  logic b_invert,
  input  logic carry_in,
  output logic and_bit,
  output logic or_bit,
  output logic sum_bit,
  output logic carry_out
);

  logic b_eff;
  logic half_sum;

  always_comb begin
    b_eff     = b_bit ^ b_invert;
    half_sum  = a_bit ^ b_eff;
    and_bit   = a_bit & b_eff;
    or_bit    = a_bit | b_eff;
    sum_bit   = half_sum ^ carry_in;
    carry_out = (a_bit & b_eff) | (half_sum & carry_in);
  end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] and_vec,
  input  logic [WIDTH-1:0] or_vec,
  input  logic [WIDTH-1:0] sum_vec,
  input  logic             set_bit,
  input  slice_sel_e       res_sel,
  input  logic             code_valid,
  output logic [WIDTH-1:0] result
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic less_in;
    logic picked;

    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_upper
      assign less_in = 1'b0;
    end

    always_comb begin
      case (res_sel)
        SEL_AND:  picked = and_vec[i];
        SEL_OR:   picked = or_vec[i];
        SEL_SUM:  picked = sum_vec[i];
        default:  picked = less_in;
      endcase
    end

    assign result[i] = picked & code_valid;
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result,
  input  logic             msb_carry_in,
  input  logic             msb_carry_out,
  input  logic             msb_sum,
  input  logic             arith_op,
  output logic             zero_flag,
  output logic             ovf_flag,
  output logic             set_bit
);

  logic ovf_raw;

  always_comb begin
    ovf_raw   = msb_carry_in ^ msb_carry_out;
    set_bit   = msb_sum ^ ovf_raw;
    ovf_flag  = ovf_raw & arith_op;
    zero_flag = ~(|result);
  end

endmodule

// File: rtl/alu_sliced_core.sv
module alu_sliced_core
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [CTL_W-1:0] alu_ctl,
  output logic [WIDTH-1:0] alu_out,
  output logic             zero_flag,
  output logic             ovf_flag
);

  localparam int MSB = WIDTH - 1;

  logic       b_invert;
  logic       carry_seed;
  slice_sel_e res_sel;
  logic       code_valid;
  logic       arith_op;
  logic       set_bit;

  logic [WIDTH-1:0] and_vec;
  logic [WIDTH-1:0] or_vec;
  logic [WIDTH-1:0] sum_vec;
  logic             carry_chain [WIDTH+1];

  alu_ctl_decode u_decode (
    .ctl_word   (alu_ctl),
    .b_invert   (b_invert),
    .carry_seed (carry_seed),
    .res_sel    (res_sel),
    .code_valid (code_valid),
    .arith_op   (arith_op)
  );

  assign carry_chain[0] = carry_seed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .b_invert  (b_invert),
      .carry_in  (carry_chain[i]),
      .and_bit   (and_vec[i]),
      .or_bit    (or_vec[i]),
      .sum_bit   (sum_vec[i]),
      .carry_out (carry_chain[i+1])
    );
  end

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .result        (alu_out),
    .msb_carry_in  (carry_chain[MSB]),
    .msb_carry_out (carry_chain[WIDTH]),
    .msb_sum       (sum_vec[MSB]),
    .arith_op      (arith_op),
    .zero_flag     (zero_flag),
    .ovf_flag      (ovf_flag),
    .set_bit       (set_bit)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .and_vec    (and_vec),
    .or_vec     (or_vec),
    .sum_vec    (sum_vec),
    .set_bit    (set_bit),
    .res_sel    (res_sel),
    .code_valid (code_valid),
    .result     (alu_out)
  );

endmodule

// File: rtl/alu_sliced_chk.sv
module alu_sliced_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       alu_ctl,
  input logic [WIDTH-1:0] alu_out,
  input logic             zero_flag,
  input logic             ovf_flag
);

  always_comb begin
    // R1
    and_subset_chk: assert (alu_ctl != 3'b000 ||
                            ((alu_out & ~opnd_a) == '0 && (alu_out & ~opnd_b) == '0));
    // R2
    or_superset_chk: assert (alu_ctl != 3'b001 ||
                             ((alu_out & opnd_a) == opnd_a && (alu_out & opnd_b) == opnd_b));
    // R3
    add_identity_chk: assert (alu_ctl != 3'b010 || opnd_b != '0 ||
                              (alu_out == opnd_a && !ovf_flag));
    // R4
    sub_self_chk: assert (alu_ctl != 3'b110 || opnd_a != opnd_b ||
                          (zero_flag && !ovf_flag));
    // R5
    slt_upper_chk: assert (alu_ctl != 3'b111 || alu_out[WIDTH-1:1] == '0);
    // R6
    zero_out_chk: assert (!zero_flag || alu_out == '0);
    // R8
    ovf_gate_chk: assert (!(alu_ctl[1] == 1'b0 || alu_ctl == 3'b111) || !ovf_flag);
    // R9
    unused_code_chk: assert (!(alu_ctl == 3'b011 || alu_ctl == 3'b100 || alu_ctl == 3'b101) ||
                             (alu_out == '0 && zero_flag));
  end

endmodule

bind alu_sliced_core alu_sliced_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .alu_ctl   (alu_ctl),
  .alu_out   (alu_out),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/alu_sliced_core_tb.sv
module alu_sliced_core_tb;

  localparam int W = 32;
  localparam int NVEC = 20;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [2:0]   ctl;
  logic [W-1:0] res;
  logic         zf;
  logic         vf;

  int checks;
  int fails;

  alu_sliced_core #(.WIDTH(W)) u_dut (
    .opnd_a    (a),
    .opnd_b    (b),
    .alu_ctl   (ctl),
    .alu_out   (res),
    .zero_flag (zf),
    .ovf_flag  (vf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {ctl, a, b}
  localparam logic [66:0] VEC [NVEC] = '{
    {3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00},
    {3'b000, 32'hDEAD_BEEF, 32'hFFFF_0000},
    {3'b001, 32'h1234_0000, 32'h0000_5678},
    {3'b001, 32'h0000_0000, 32'h0000_0000},
    {3'b010, 32'h0000_0007, 32'h0000_0009},
    {3'b010, 32'h7FFF_FFFF, 32'h0000_0001},
    {3'b010, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'b010, 32'h8000_0000, 32'h8000_0000},
    {3'b110, 32'h0000_0007, 32'h0000_0002},
    {3'b110, 32'h0000_0002, 32'h0000_0007},
    {3'b110, 32'h8000_0000, 32'h0000_0001},
    {3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {3'b111, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'b111, 32'h0000_0001, 32'hFFFF_FFFF},
    {3'b111, 32'h8000_0000, 32'h0000_0001},
    {3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {3'b111, 32'h0000_0005, 32'h0000_0005},
    {3'b011, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'b100, 32'hAAAA_AAAA, 32'h5555_5555},
    {3'b101, 32'h8000_0000, 32'h8000_0000}
  };

  function automatic string op_tag(input logic [2:0] c);
    case (c)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R9";
    endcase
  endfunction

  // Model built from the requirements: {result, zero, overflow}
  function automatic logic [W+1:0] ref_alu(input logic [2:0] c,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
    logic [W-1:0] r;
    logic         v;
    v = 1'b0;
    case (c)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b010: begin
        r = x + y;
        v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
      end
      3'b110: begin
        r = x - y;
        v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
      end
      3'b111: r = ($signed(x) < $signed(y)) ? {{(W-1){1'b0}}, 1'b1} : '0;
      default: r = '0;
    endcase
    return {r, (r == '0), v};
  endfunction

  task automatic check_val(input string tag, input string what,
                           input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s ctl=%b a=%h b=%h actual=%h expected=%h",
               tag, what, ctl, a, b, got, exp);
    end
  endtask

  // Drive after a rising edge, sample at the following falling edge
  task automatic apply(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    ctl = c;
    a   = x;
    b   = y;
    @(negedge clk);
  endtask

  task automatic run_model(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W+1:0] e;
    apply(c, x, y);
    e = ref_alu(c, x, y);
    check_val(op_tag(c), "result", res, e[W+1:2]);
    check_val("R6", "zero", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, e[1]});
    check_val((c == 3'b010 || c == 3'b110) ? "R7" : "R8", "ovf",
              {{(W-1){1'b0}}, vf}, {{(W-1){1'b0}}, e[0]});
  endtask

  task automatic directed(input string tag, input logic [2:0] c,
                          input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic [W-1:0] er, input logic ez, input logic ev);
    apply(c, x, y);
    check_val(tag, "result", res, er);
    check_val(tag, "zero", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, ez});
    check_val(tag, "ovf", {{(W-1){1'b0}}, vf}, {{(W-1){1'b0}}, ev});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    ctl    = 3'b000;
    a      = '0;
    b      = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: AND of zeros gives zero result, zero flag set (R1, R6, R8)
    @(negedge clk);
    check_val("R1", "idle result", res, '0);
    check_val("R6", "idle zero", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, 1'b1});
    check_val("R8", "idle ovf", {{(W-1){1'b0}}, vf}, '0);

    for (int i = 0; i < NVEC; i++) begin
      run_model(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R5: compare across an overflowing subtraction
    directed("R5", 3'b111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0);
    directed("R5", 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);
    // R7: positive wrap into the sign bit, and carry-out without overflow
    directed("R7", 3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1);
    directed("R7", 3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0);
    directed("R7", 3'b110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1);
    // R4 with R6: equality test through subtract
    directed("R4", 3'b110, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 1'b1, 1'b0);
    // R8: logic op on operands that would overflow if added
    directed("R8", 3'b001, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    directed("R1", 3'b000, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 1'b1, 1'b0);
    // R9: unused codes return zero
    directed("R9", 3'b011, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0);
    directed("R9", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);
    directed("R9", 3'b101, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0);

    finish_run();
  end

endmodule